// File: doc/BRIEF.md
# Nibble-Serial Indirect Register Bridge

This bridge lets an external master reach a 16-bit-addressed internal register space through a narrow command channel. The master first writes a command address that picks one of three indirect ports: address low byte, address high byte, or data byte. It then sends the byte for that port as two command-data writes. The upper nibble comes first and the lower nibble second, each in the low four bits of the command word.

When a byte for an address port is complete, it is latched into the matching half of the target address. When a byte for the data port is complete, the bridge issues a one-cycle write strobe to the register space at the assembled address. A read request returns the register value at the current address. The register space is modelled by a small block-RAM-style file indexed by the low bits of the address.

Top module: `nrb_bridge`

## Requirements
- R1: During and right after a synchronous active-high reset, wr_stb, rd_valid, wr_addr, wr_data and rd_data are all zero. No command port is selected, and the nibble phase expects an upper nibble.
- R2: A command-address write of 0x3A followed by nibble writes h then l makes wr_addr[7:0] equal {h,l} in the cycle after the second nibble. wr_addr[15:8] does not change.
- R3: A command-address write of 0x3B followed by nibble writes h then l makes wr_addr[15:8] equal {h,l} in the cycle after the second nibble. wr_addr[7:0] does not change.
- R4: A command-address write of 0x3C followed by nibble writes h then l raises wr_stb for exactly one cycle, in the cycle after the second nibble. In that cycle wr_data equals {h,l} and wr_addr holds the assembled address.
- R5: A lone first nibble changes no output. Idle cycles between the two nibbles of a pair do not break the pair.
- R6: Any command-address write resets the nibble phase to expect an upper nibble. A pending upper nibble is discarded.
- R7: A command-data write is ignored while no port is selected. This holds after reset and after a command address other than 0x3A, 0x3B or 0x3C.
- R8: Only bits [3:0] of a command-data word carry the nibble. Bits [7:4] have no effect.
- R9: The port selection and the assembled address persist after a byte completes. Further nibble pairs without a new command address go to the same port, and each pair to the data port gives its own strobe at the same address.
- R10: A rd_req sampled at a clock edge gives rd_valid high for one cycle after that edge. In that cycle rd_data is the stored value at index wr_addr[IDX_W-1:0], and rd_data holds its value when there is no request.
- R11: A strobed byte is stored at index wr_addr[IDX_W-1:0] on the clock edge that ends the strobe cycle. A read sampled on that same edge returns the previous contents.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_wr | input | 1 | Command write valid for one cycle |
| cmd_is_addr | input | 1 | 1: cmd_word is a command address; 0: it is command data |
| cmd_word | input | CMD_W | Command address, or a nibble in bits [3:0] |
| rd_req | input | 1 | Read the register at the assembled address |
| rd_data | output | 8 | Read data |
| rd_valid | output | 1 | rd_data is fresh this cycle |
| wr_stb | output | 1 | One-cycle write strobe to the register space |
| wr_addr | output | 16 | Assembled target address |
| wr_data | output | 8 | Byte written with the strobe |

## Verification
The bench goes after nibble ordering, where a design that swaps nibbles writes 0x61 instead of 0x16. It checks phase reset on reselection: a design that keeps a stale upper nibble assembles 0x45 where 0x55 is due. It also checks that writes with no port selected and the upper data bits are ignored, where a faulty design moves the address or strobes spuriously. It then probes persistence of address and port across repeated data bytes, a read that lands on the same edge as a write, where a write-first file returns new data, and a long mixed stream against the cycle model.

// File: rtl/nrb_pkg.sv
package nrb_pkg;
  localparam int NIB_W  = 4;
  localparam int BYTE_W = 2 * NIB_W;
  localparam int ADDR_W = 2 * BYTE_W;

  typedef enum logic [1:0] {
    PORT_NONE    = 2'd0,
    PORT_ADDR_LO = 2'd1,
    PORT_ADDR_HI = 2'd2,
    PORT_DATA    = 2'd3
  } port_e;

  function automatic port_e lane_port(input int lane);
    return (lane == 0) ? PORT_ADDR_LO : PORT_ADDR_HI;
  endfunction
endpackage

// File: rtl/nrb_nibble_rx.sv
module nrb_nibble_rx
  import nrb_pkg::*;
#(
  parameter int          CMD_W     = 8,
  parameter logic [7:0]  CODE_LO   = 8'h3A,
  parameter logic [7:0]  CODE_HI   = 8'h3B,
  parameter logic [7:0]  CODE_DATA = 8'h3C
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cmd_wr,
  input  logic              cmd_is_addr,
  input  logic [CMD_W-1:0]  cmd_word,
  output logic              byte_vld,
  output port_e             byte_port,
  output logic [BYTE_W-1:0] byte_val
);
  port_e             sel_q;
  logic              lower_due_q;
  logic [NIB_W-1:0]  upper_q;
  logic              data_wr;
  port_e             sel_dec;

  assign data_wr = cmd_wr && !cmd_is_addr && (sel_q != PORT_NONE);

  always_comb begin
    sel_dec = PORT_NONE;
    if (cmd_word[7:0] == CODE_LO)        sel_dec = PORT_ADDR_LO;
    else if (cmd_word[7:0] == CODE_HI)   sel_dec = PORT_ADDR_HI;
    else if (cmd_word[7:0] == CODE_DATA) sel_dec = PORT_DATA;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      sel_q       <= PORT_NONE;
      lower_due_q <= 1'b0;
      upper_q     <= '0;
    end else if (cmd_wr && cmd_is_addr) begin
      sel_q       <= sel_dec;
      lower_due_q <= 1'b0;
    end else if (data_wr) begin
      lower_due_q <= !lower_due_q;
      if (!lower_due_q) upper_q <= cmd_word[NIB_W-1:0];
    end
  end

  assign byte_vld  = data_wr && lower_due_q;
  assign byte_port = sel_q;
  assign byte_val  = {upper_q, cmd_word[NIB_W-1:0]};
endmodule

// File: rtl/nrb_core.sv
module nrb_core
  import nrb_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              byte_vld,
  input  port_e             byte_port,
  input  logic [BYTE_W-1:0] byte_val,
  output logic [ADDR_W-1:0] addr,
  output logic              stb,
  output logic [BYTE_W-1:0] wdata
);
  localparam int LANES = ADDR_W / BYTE_W;

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    always_ff @(posedge clk) begin
      if (rst)
        addr[g*BYTE_W +: BYTE_W] <= '0;
      else if (byte_vld && byte_port == lane_port(g))
        addr[g*BYTE_W +: BYTE_W] <= byte_val;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      stb   <= 1'b0;
      wdata <= '0;
    end else begin
      stb <= byte_vld && (byte_port == PORT_DATA);
      if (byte_vld && byte_port == PORT_DATA) wdata <= byte_val;
    end
  end
endmodule

// File: rtl/nrb_regfile.sv
module nrb_regfile #(
  parameter int DATA_W = 8,
  parameter int IDX_W  = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              we,
  input  logic [IDX_W-1:0]  waddr,
  input  logic [DATA_W-1:0] wdata,
  input  logic              re,
  input  logic [IDX_W-1:0]  raddr,
  output logic [DATA_W-1:0] rdata,
  output logic              rvalid
);
  localparam int DEPTH = 1 << IDX_W;

  logic [DATA_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rdata  <= '0;
      rvalid <= 1'b0;
    end else begin
      rvalid <= re;
      if (re) rdata <= mem[raddr];
    end
  end
endmodule

// File: rtl/nrb_bridge.sv
module nrb_bridge
  import nrb_pkg::*;
#(
  parameter int         CMD_W     = 8,
  parameter int         IDX_W     = 8,
  parameter logic [7:0] CODE_LO   = 8'h3A,
  parameter logic [7:0] CODE_HI   = 8'h3B,
  parameter logic [7:0] CODE_DATA = 8'h3C
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cmd_wr,
  input  logic              cmd_is_addr,
  input  logic [CMD_W-1:0]  cmd_word,
  input  logic              rd_req,
  output logic [BYTE_W-1:0] rd_data,
  output logic              rd_valid,
  output logic              wr_stb,
  output logic [ADDR_W-1:0] wr_addr,
  output logic [BYTE_W-1:0] wr_data
);
  logic              byte_vld;
  port_e             byte_port;
  logic [BYTE_W-1:0] byte_val;

  nrb_nibble_rx #(
    .CMD_W(CMD_W), .CODE_LO(CODE_LO), .CODE_HI(CODE_HI), .CODE_DATA(CODE_DATA)
  ) u_rx (
    .clk(clk), .rst(rst), .cmd_wr(cmd_wr), .cmd_is_addr(cmd_is_addr),
    .cmd_word(cmd_word), .byte_vld(byte_vld), .byte_port(byte_port),
    .byte_val(byte_val)
  );

  nrb_core u_core (
    .clk(clk), .rst(rst), .byte_vld(byte_vld), .byte_port(byte_port),
    .byte_val(byte_val), .addr(wr_addr), .stb(wr_stb), .wdata(wr_data)
  );

  nrb_regfile #(.DATA_W(BYTE_W), .IDX_W(IDX_W)) u_rf (
    .clk(clk), .rst(rst), .we(wr_stb), .waddr(wr_addr[IDX_W-1:0]),
    .wdata(wr_data), .re(rd_req), .raddr(wr_addr[IDX_W-1:0]),
    .rdata(rd_data), .rvalid(rd_valid)
  );
endmodule

// File: rtl/nrb_bridge_chk.sv
module nrb_bridge_chk (
  input logic        clk,
  input logic        rst,
  input logic        cmd_wr,
  input logic        cmd_is_addr,
  input logic        rd_req,
  input logic        rd_valid,
  input logic        wr_stb,
  input logic [15:0] wr_addr
);
  AST_STB_SINGLE: assert property (@(posedge clk) disable iff (rst)
    wr_stb |=> !wr_stb); // R4

  AST_STB_FROM_DATA: assert property (@(posedge clk) disable iff (rst)
    wr_stb |-> $past(cmd_wr && !cmd_is_addr)); // R4

  AST_SELECT_QUIET: assert property (@(posedge clk) disable iff (rst)
    (cmd_wr && cmd_is_addr) |=> (!wr_stb && $stable(wr_addr))); // R6

  AST_ADDR_HOLD: assert property (@(posedge clk) disable iff (rst)
    !$past(cmd_wr) |-> $stable(wr_addr)); // R9

  AST_RD_FOLLOWS: assert property (@(posedge clk) disable iff (rst)
    rd_req |=> rd_valid); // R10

  AST_RD_CAUSED: assert property (@(posedge clk) disable iff (rst)
    rd_valid |-> $past(rd_req)); // R10
endmodule

bind nrb_bridge nrb_bridge_chk u_chk (
  .clk(clk), .rst(rst), .cmd_wr(cmd_wr), .cmd_is_addr(cmd_is_addr),
  .rd_req(rd_req), .rd_valid(rd_valid), .wr_stb(wr_stb), .wr_addr(wr_addr)
);

// File: tb/nrb_bridge_tb.sv
module nrb_bridge_tb;
  localparam int CLK_PERIOD = 10;
  localparam int IDX_W      = 8;
  localparam int WATCHDOG   = 20000;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       cmd_wr = 1'b0;
  logic       cmd_is_addr = 1'b0;
  logic [7:0] cmd_word = '0;
  logic       rd_req = 1'b0;
  logic [7:0] rd_data;
  logic       rd_valid;
  logic       wr_stb;
  logic [15:0] wr_addr;
  logic [7:0] wr_data;

  always #(CLK_PERIOD/2) clk = ~clk;

  nrb_bridge #(.IDX_W(IDX_W)) u_dut (
    .clk(clk), .rst(rst), .cmd_wr(cmd_wr), .cmd_is_addr(cmd_is_addr),
    .cmd_word(cmd_word), .rd_req(rd_req), .rd_data(rd_data),
    .rd_valid(rd_valid), .wr_stb(wr_stb), .wr_addr(wr_addr), .wr_data(wr_data)
  );

  // behavioural reference
  int    m_sel, m_phase, m_up, m_addr, m_wdata, m_rdata;
  bit    m_stb, m_rdv;
  int    m_mem [int];
  int    vectors = 0, fails = 0, cycles = 0;
  string cur_req = "R1";

  always @(posedge clk) begin
    cycles++;
    if (rst) begin
      m_sel = 0; m_phase = 0; m_up = 0; m_addr = 0; m_wdata = 0;
      m_rdata = 0; m_stb = 0; m_rdv = 0;
    end else begin
      int idx, code, nib;
      bit nstb;
      idx = m_addr % (1 << IDX_W);
      m_rdv = rd_req;
      if (rd_req) m_rdata = m_mem.exists(idx) ? m_mem[idx] : 0;
      if (m_stb) m_mem[idx] = m_wdata;
      nstb = 0;
      if (cmd_wr && cmd_is_addr) begin
        code = cmd_word;
        m_sel = (code == 'h3A) ? 1 : (code == 'h3B) ? 2 : (code == 'h3C) ? 3 : 0;
        m_phase = 0;
      end else if (cmd_wr && m_sel != 0) begin
        nib = cmd_word % 16;
        if (m_phase == 0) begin
          m_up = nib; m_phase = 1;
        end else begin
          m_phase = 0;
          case (m_sel)
            1: m_addr = (m_addr / 256) * 256 + m_up * 16 + nib;
            2: m_addr = (m_up * 16 + nib) * 256 + m_addr % 256;
            default: begin nstb = 1; m_wdata = m_up * 16 + nib; end
          endcase
        end
      end
      m_stb = nstb;
    end
  end

  task automatic fail_line(string what, int act, int exp);
    fails++;
    $display("FAIL %s %s actual=%0h expected=%0h", cur_req, what, act, exp);
  endtask

  always @(negedge clk) begin
    if (cycles > 0) begin
      vectors++;
      if (wr_stb !== m_stb)          fail_line("wr_stb", wr_stb, m_stb);
      if (wr_addr !== m_addr[15:0])  fail_line("wr_addr", wr_addr, m_addr);
      if (wr_data !== m_wdata[7:0])  fail_line("wr_data", wr_data, m_wdata);
      if (rd_valid !== m_rdv)        fail_line("rd_valid", rd_valid, m_rdv);
      if (m_rdv && rd_data !== m_rdata[7:0]) fail_line("rd_data", rd_data, m_rdata);
    end
  end

  task automatic sel(input logic [7:0] c);
    @(negedge clk); cmd_wr = 1; cmd_is_addr = 1; cmd_word = c; rd_req = 0;
    @(negedge clk); cmd_wr = 0;
  endtask

  task automatic nib(input logic [7:0] w);
    @(negedge clk); cmd_wr = 1; cmd_is_addr = 0; cmd_word = w; rd_req = 0;
    @(negedge clk); cmd_wr = 0;
  endtask

  task automatic pair(input logic [7:0] hi, input logic [7:0] lo);
    nib(hi); nib(lo);
  endtask

  task automatic rd();
    @(negedge clk); rd_req = 1; cmd_wr = 0;
    @(negedge clk); rd_req = 0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    cur_req = "R1";
    vectors++;
    if (wr_stb !== 0 || rd_valid !== 0 || wr_addr !== 0 || wr_data !== 0 || rd_data !== 0)
      fail_line("reset outputs", {wr_stb, rd_valid, wr_addr}, 0);
    rst = 0;
    idle(2);
    cur_req = "R7"; pair(8'h5, 8'h7); idle(2);
    cur_req = "R2"; sel(8'h3A); pair(8'h8, 8'h3); idle(1);
    cur_req = "R3"; sel(8'h3B); pair(8'hE, 8'h6); idle(1);
    cur_req = "R4"; sel(8'h3C); pair(8'h1, 8'h6); idle(2);
    cur_req = "R9"; sel(8'h3C); pair(8'h3, 8'h6); idle(1); pair(8'hA, 8'h5); idle(1);
    cur_req = "R10"; rd(); idle(1);
    cur_req = "R8"; sel(8'h3A); pair(8'hF2, 8'h71); sel(8'h3C); pair(8'hBC, 8'h94); idle(2); rd();
    cur_req = "R6"; sel(8'h3A); nib(8'h4); sel(8'h3A); pair(8'h5, 8'h5); idle(1);
    cur_req = "R5"; sel(8'h3C); nib(8'h7); idle(4); nib(8'h0); idle(2); rd();
    cur_req = "R7"; sel(8'h3D); pair(8'h1, 8'h2); idle(2);
    cur_req = "R11"; sel(8'h3C); nib(8'hC);
    @(negedge clk); cmd_wr = 1; cmd_is_addr = 0; cmd_word = 8'h3;
    @(negedge clk); cmd_wr = 0; rd_req = 1;
    @(negedge clk); rd_req = 0;
    rd(); idle(2);
    cur_req = "R4 mixed";
    for (int i = 0; i < 600; i++) begin
      int r;
      r = $urandom_range(0, 9);
      if (r < 3) begin
        logic [7:0] codes [4];
        codes = '{8'h3A, 8'h3B, 8'h3C, 8'h20};
        sel(codes[$urandom_range(0, 3)]);
      end else if (r < 8) nib(8'($urandom_range(0, 255)));
      else idle(1);
    end
    idle(3);
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired actual=%0d expected<%0d", WATCHDOG, WATCHDOG);
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end
endmodule